// File: doc/BRIEF.md
# Paged Indexed Effective Address Unit

This unit turns a single 16-bit instruction word into the memory address that the instruction refers to. The low eleven bits of the instruction carry an address field. In the default mode that field sits inside a 2K page chosen by a small page register. When the instruction's relative flag is set, the field is instead an offset from the program counter. When the instruction's index flag is set, the 16-bit index register is added to the result. The unit produces word addresses (15 bits) or byte addresses (16 bits), as selected by a mode input.

Software moves between pages by loading the 5-bit page register through its own write port. The calculation is combinational. The result is captured one clock after an instruction strobe, and a two-state controller, IDLE and EMIT, marks the cycle in which it is valid. In IDLE the output is quiet. When a strobe arrives, the transition GO takes the controller to EMIT. In EMIT, a further strobe takes the transition AGAIN and the controller stays in EMIT; without a strobe the transition DONE returns it to IDLE.

Top module: `eau_top`

## Requirements
- R1: After reset, `ea_valid` is 0, `ea` is 0 and the page register holds 0. A paged word-mode instruction issued before any page write therefore yields the bare 11-bit field.
- R2: `ea_valid` is 1 in the cycle after each cycle in which `instr_valid` is 1, and 0 in every other cycle.
- R3: The instruction layout is fixed. The opcode is in bits [15:12], the relative flag is bit 11, and the address field is bits [10:0]. The index flag is opcode bit 12.
- R4: A paged word-mode instruction (relative 0, index 0, `byte_mode` 0) gives `ea = {1'b0, page[3:0], field}`. Bit 15 of `ea` is always 0 in word mode.
- R5: A paged byte-mode instruction (relative 0, index 0, `byte_mode` 1) gives `ea = {page[4:0], field}`.
- R6: A relative instruction ignores the page register. In word mode, `ea[14:0] = (pc + field) mod 2^15`. In byte mode, `ea = (2*pc + field) mod 2^16`.
- R7: When the index flag is 1, `ixr` is added to the paged or relative address. The sum wraps modulo 2^15 in word mode and modulo 2^16 in byte mode.
- R8: When `exr_wr_en` is 1 at a clock edge, the page register loads `exr_wr_data`. An instruction strobed in that same cycle still uses the old page value. Later instructions use the new one.
- R9: `ea` holds its last value in every cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Strobe: capture an address for `instr` this cycle |
| instr | input | 16 | Instruction word |
| pc | input | 15 | Program counter (word address) |
| ixr | input | 16 | Index register value |
| byte_mode | input | 1 | 1 selects byte addressing, 0 selects word addressing |
| exr_wr_en | input | 1 | Page register write enable |
| exr_wr_data | input | 5 | New page register value |
| ea_valid | output | 1 | Effective address valid this cycle |
| ea | output | 16 | Effective address |

## Verification
The bench sweeps every combination of mode, relative flag and index flag. Each combination runs across page values, field edges (0, 0x3FF, 0x400, 0x7FF), program counters and index values near the wrap point.

The sweep targets several specific mistakes:
- Using the wrong number of page bits in word mode would set bit 15 or duplicate the top page bit.
- Forgetting to double the PC in byte-relative mode would produce half the expected offset.
- Wrapping the index sum at the wrong width would leak a carry into bit 15 of a word address.

A page write in the same cycle as a strobe is checked separately. A design that bypassed the new value would show the new page one instruction early.

// File: rtl/eau_pkg.sv
package eau_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } eau_state_e;
endpackage

// File: rtl/eau_exr_reg.sv
module eau_exr_reg #(
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_data,
    output logic [PAGE_W-1:0] page_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (wr_en) begin
            page_q <= wr_data;
        end
    end
endmodule

// File: rtl/eau_addr_calc.sv
module eau_addr_calc #(
    parameter int FIELD_W = 11,
    parameter int PAGE_W  = 5,
    parameter int DATA_W  = 16,
    localparam int WAW    = FIELD_W + PAGE_W - 1,
    localparam int BAW    = FIELD_W + PAGE_W
) (
    input  logic [FIELD_W-1:0] field,
    input  logic               rel,
    input  logic               idx,
    input  logic               byte_mode,
    input  logic [WAW-1:0]     pc,
    input  logic [PAGE_W-1:0]  page,
    input  logic [DATA_W-1:0]  ixr,
    output logic [DATA_W-1:0]  ea_next
);
    logic [WAW-1:0] word_base;
    logic [WAW-1:0] word_sum;
    logic [BAW-1:0] byte_base;
    logic [BAW-1:0] byte_sum;
    logic [WAW-1:0] word_off;
    logic [BAW-1:0] byte_off;

    always_comb begin
        word_off = idx ? ixr[WAW-1:0] : '0;
        byte_off = idx ? BAW'(ixr) : '0;

        if (rel) begin
            word_base = pc + WAW'(field);
            byte_base = {pc, 1'b0} + BAW'(field);
        end else begin
            word_base = {page[PAGE_W-2:0], field};
            byte_base = {page, field};
        end

        word_sum = word_base + word_off;
        byte_sum = byte_base + byte_off;

        if (byte_mode) begin
            ea_next = DATA_W'(byte_sum);
        end else begin
            ea_next = DATA_W'(word_sum);
        end
    end
endmodule

// File: rtl/eau_top.sv
module eau_top #(
    parameter int FIELD_W = 11,
    parameter int PAGE_W  = 5,
    parameter int DATA_W  = 16,
    parameter int REL_BIT = 11,
    parameter int IDX_BIT = 12,
    localparam int PC_W   = FIELD_W + PAGE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [DATA_W-1:0] instr,
    input  logic [PC_W-1:0]   pc,
    input  logic [DATA_W-1:0] ixr,
    input  logic              byte_mode,
    input  logic              exr_wr_en,
    input  logic [PAGE_W-1:0] exr_wr_data,
    output logic              ea_valid,
    output logic [DATA_W-1:0] ea
);
    import eau_pkg::*;

    eau_state_e        state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] ea_next;
    logic [DATA_W-1:0] ea_q;
    logic              opcode_unused;

    assign opcode_unused = ^instr;

    eau_exr_reg #(.PAGE_W(PAGE_W)) exr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (exr_wr_en),
        .wr_data (exr_wr_data),
        .page_q  (page_q)
    );

    eau_addr_calc #(
        .FIELD_W (FIELD_W),
        .PAGE_W  (PAGE_W),
        .DATA_W  (DATA_W)
    ) calc_i (
        .field     (instr[FIELD_W-1:0]),
        .rel       (instr[REL_BIT]),
        .idx       (instr[IDX_BIT]),
        .byte_mode (byte_mode),
        .pc        (pc),
        .page      (page_q),
        .ixr       (ixr),
        .ea_next   (ea_next)
    );

    // next-state logic: GO / AGAIN on a strobe, DONE without one
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = instr_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = instr_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    // state and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ea_q    <= '0;
        end else begin
            state_q <= state_d;
            if (instr_valid) begin
                ea_q <= ea_next;
            end
        end
    end

    // outputs
    always_comb begin
        ea = ea_q;
        unique case (state_q)
            ST_IDLE: ea_valid = 1'b0;
            ST_EMIT: ea_valid = 1'b1;
        endcase
    end
endmodule

// File: rtl/eau_chk.sv
module eau_chk #(
    parameter int FIELD_W = 11,
    parameter int PAGE_W  = 5,
    parameter int DATA_W  = 16,
    parameter int REL_BIT = 11,
    parameter int IDX_BIT = 12,
    localparam int PC_W   = FIELD_W + PAGE_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [DATA_W-1:0] instr,
    input logic [PC_W-1:0]   pc,
    input logic              byte_mode,
    input logic              ea_valid,
    input logic [DATA_W-1:0] ea
);
    logic [PC_W-1:0] fld_ext;
    assign fld_ext = PC_W'(instr[FIELD_W-1:0]);

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> ea_valid); // R2
    AST_VALID_ONLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !ea_valid); // R2
    AST_WORD_TOP_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !byte_mode) |=> !ea[DATA_W-1]); // R4
    AST_EA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(ea)); // R9
    AST_REL_WORD_FROM_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[REL_BIT] && !instr[IDX_BIT] && !byte_mode)
        |=> (ea[PC_W-1:0] == $past(pc) + $past(fld_ext))); // R6
endmodule

bind eau_top eau_chk #(
    .FIELD_W (FIELD_W),
    .PAGE_W  (PAGE_W),
    .DATA_W  (DATA_W),
    .REL_BIT (REL_BIT),
    .IDX_BIT (IDX_BIT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .pc          (pc),
    .byte_mode   (byte_mode),
    .ea_valid    (ea_valid),
    .ea          (ea)
);

// File: tb/eau_top_tb_top.sv
module eau_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [14:0] pc = '0;
    logic [15:0] ixr = '0;
    logic        byte_mode = 1'b0;
    logic        exr_wr_en = 1'b0;
    logic [4:0]  exr_wr_data = '0;
    logic        ea_valid;
    logic [15:0] ea;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    eau_top dut_i (
        .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr (instr),
        .pc (pc), .ixr (ixr), .byte_mode (byte_mode), .exr_wr_en (exr_wr_en),
        .exr_wr_data (exr_wr_data), .ea_valid (ea_valid), .ea (ea)
    );

    function automatic int calc_ea(int bm, int rel, int idx, int page, int fld, int p, int x);
        int base;
        if (bm != 0) begin
            base = (rel != 0) ? (p * 2 + fld) : (page * 2048 + fld);
            return (base + ((idx != 0) ? x : 0)) & 32'hFFFF;
        end
        base = (rel != 0) ? (p + fld) : ((page & 15) * 2048 + fld);
        return (base + ((idx != 0) ? x : 0)) & 32'h7FFF;
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    // issue one instruction at a negedge; check the result one clock later
    task automatic issue(string req, int bm, int rel, int idx, int fld, int p, int x, int expected);
        instr_valid = 1'b1;
        instr = {3'b101, idx[0], rel[0], fld[10:0]};
        byte_mode = bm[0];
        pc = p[14:0];
        ixr = x[15:0];
        @(negedge clk);
        instr_valid = 1'b0;
        check({req, " valid"}, int'(ea_valid), 1);
        check(req, int'(ea), expected);
    endtask

    task automatic write_page(int v);
        exr_wr_en = 1'b1;
        exr_wr_data = v[4:0];
        @(negedge clk);
        exr_wr_en = 1'b0;
    endtask

    initial begin
        int fields[6] = '{0, 1, 16'h3FF, 16'h400, 16'h7FF, 16'h2A5};
        int pcs[3] = '{0, 16'h7FFF, 16'h1234};
        int ixs[4] = '{0, 1, 16'hFFFF, 16'h8000};
        int pages[8] = '{0, 1, 5, 15, 16, 17, 30, 31};
        int last;

        repeat (3) @(negedge clk);
        check("R1 ea_valid reset", int'(ea_valid), 0);
        check("R1 ea reset", int'(ea), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", int'(ea_valid), 0);
        issue("R1 page reset zero", 0, 0, 0, 16'h5A3, 0, 0, 16'h5A3);

        // full sweep: R3 R4 R5 R6 R7
        foreach (pages[pi]) begin
            write_page(pages[pi]);
            for (int bm = 0; bm < 2; bm++)
                for (int rel = 0; rel < 2; rel++)
                    for (int idx = 0; idx < 2; idx++)
                        foreach (fields[fi])
                            foreach (pcs[ci])
                                foreach (ixs[xi])
                                    issue(bm != 0 ? (rel != 0 ? "R6 byte rel" : (idx != 0 ? "R7 byte idx" : "R5 byte paged"))
                                                  : (rel != 0 ? "R6 word rel" : (idx != 0 ? "R7 word idx" : "R4 word paged")),
                                          bm, rel, idx, fields[fi], pcs[ci], ixs[xi],
                                          calc_ea(bm, rel, idx, pages[pi], fields[fi], pcs[ci], ixs[xi]));
        end

        // R9: hold with changing inputs and no strobe
        issue("R3 layout", 1, 0, 1, 16'h123, 0, 16'h10, calc_ea(1, 0, 1, 31, 16'h123, 0, 16'h10));
        last = int'(ea);
        instr = 16'hFFFF; pc = 15'h7ABC; ixr = 16'h5555; byte_mode = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R9 hold", int'(ea), last);
            check("R2 no strobe", int'(ea_valid), 0);
        end

        // R8: page write in the same cycle as a strobe uses the old page
        write_page(3);
        exr_wr_en = 1'b1;
        exr_wr_data = 5'd9;
        issue("R8 same cycle old page", 0, 0, 0, 16'h011, 0, 0, 3 * 2048 + 16'h011);
        exr_wr_en = 1'b0;
        issue("R8 new page after", 0, 0, 0, 16'h011, 0, 0, 9 * 2048 + 16'h011);
        issue("R8 new page byte", 1, 0, 0, 16'h011, 0, 0, 9 * 2048 + 16'h011);

        // R2: back-to-back strobes keep valid high
        instr_valid = 1'b1;
        instr = {5'b10100, 11'h001};
        byte_mode = 1'b0;
        @(negedge clk);
        check("R2 back-to-back 1", int'(ea_valid), 1);
        instr = {5'b10100, 11'h002};
        @(negedge clk);
        instr_valid = 1'b0;
        check("R2 back-to-back 2", int'(ea_valid), 1);
        check("R2 back-to-back value", int'(ea), 9 * 2048 + 2);
        @(negedge clk);
        check("R2 drop", int'(ea_valid), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule